// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block chooses which of four oscillators drives the system clock: the primary oscillator, the internal mid/high-frequency oscillator, the always-running low-frequency internal oscillator and the low-power secondary oscillator. Software sets a 2-bit select code. The block starts a handover only when the requested oscillator reports that it is usable, and it never starts a second handover while one is still in flight. Each oscillator has a gating lane of its own, clocked by that oscillator. A lane opens only after every other lane has been seen closed, so the merged system clock never carries a shortened pulse.

The control logic runs on the low-frequency internal oscillator, which never stops. It drives three status flags that tell software which source is in use. It also handles power-down requests. A request taken while the idle-enable input is high stops only the core clock and leaves the peripheral clock running. A request taken while idle-enable is low stops both clocks. A wake pulse restores both clocks and leaves the chosen source as it was. A strap input lets the internal oscillator stand in as the primary source.

Top module: `clk_source_switch`

## Requirements
- R1: After reset the primary-active flag is 1 and the other two flags are 0, with select code 00 the system clock comes from the primary oscillator, and both the core clock and the peripheral clock run.
- R2: With the strap low, the select code picks the source as follows: 00 the primary oscillator, 01 the secondary oscillator, 10 the internal oscillator, 11 the low-frequency oscillator. Once the switch has settled, the system clock period equals the period of the chosen source.
- R3: The flags {primary-active, internal-stable, secondary-running} read 100 on the primary source, 010 on a stable internal source, 001 on the secondary source and 000 on the low-frequency source. With the strap high, code 00 runs from the internal oscillator and the flags read 110.
- R4: At most one source lane is enabled at any time. No high or low phase of the system clock is shorter than the shortest source half-period.
- R5: During a switch the system clock stays low for at least two and at most three periods of the incoming clock. The busy output is high from the moment a new code is accepted until the new lane is confirmed on, and when busy falls the enabled lane is the requested one.
- R6: A code whose source is not ready (primary ready low, or internal stable low) is not acted on. The block keeps running on the current source with flags unchanged, and it switches once the ready input rises.
- R7: A switch to the secondary source waits for the secondary ready input, unless the secondary keep-alive input is high, in which case it starts without waiting.
- R8: A code change that arrives while a switch is in progress is held off. The running switch completes first, and only then does the block follow the new code.
- R9: A power-down request taken with idle-enable high stops only the core clock. Taken with idle-enable low, it stops both the core and the peripheral clocks. Changing idle-enable afterwards does not alter the mode already entered.
- R10: A wake pulse restarts both gated clocks and leaves the selected source and its flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset |
| pri_clk | input | 1 | Primary oscillator clock |
| int_clk | input | 1 | Internal mid/high-frequency oscillator clock |
| lf_clk | input | 1 | Low-frequency internal oscillator; also clocks the control logic |
| sec_clk | input | 1 | Secondary low-power oscillator clock |
| pri_rdy | input | 1 | Primary oscillator is usable |
| int_stable | input | 1 | Internal oscillator output is stable |
| sec_rdy | input | 1 | Secondary oscillator start-up has finished |
| sec_keep | input | 1 | Secondary oscillator is held running, so no start-up wait is needed |
| int_as_pri | input | 1 | Strap: the internal oscillator acts as the primary source |
| src_sel | input | 2 | Requested source code |
| sleep_req | input | 1 | One-cycle power-down request (lf_clk domain) |
| idle_en | input | 1 | Chooses core-only stop (1) or full stop (0) |
| wake | input | 1 | One-cycle wake request (lf_clk domain) |
| sys_clk | output | 1 | Merged, glitch-free system clock |
| cpu_clk | output | 1 | Core clock, gated by the power mode |
| per_clk | output | 1 | Peripheral clock, gated by the power mode |
| flag_pri | output | 1 | Primary-active status flag |
| flag_int | output | 1 | Internal-stable status flag |
| flag_sec | output | 1 | Secondary-running status flag |
| switch_busy | output | 1 | A handover is in progress |

## Verification
A code change is registered at the next lf_clk edge. The outgoing lane closes about two and a half outgoing periods later, and the incoming lane opens two to three incoming periods after that. The acknowledgement then takes two more lf_clk cycles to reach the control logic, so flags and busy settle within roughly fifteen control cycles. The bench therefore drives inputs on lf_clk falling edges and reads flags, busy and the measured system clock period forty control cycles after each code change (sixty after reset with the strap high). The longest low phase of the system clock is timed across each switch window and compared with two and three incoming periods. Power-mode effects reach the gated clocks within three system clock periods, so the bench waits ten control cycles before it counts gated edges over a twenty-cycle window.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    localparam int NSRC = 4;

    // lane index order is also the bit order of every per-source vector
    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_INT = 2'd1,
        SRC_SEC = 2'd2,
        SRC_LF  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pmode_e;

    typedef struct packed {
        src_e             want;
        src_e             cur;
        logic             busy;
        pmode_e           pmode;
        logic [NSRC-1:0]  ack_a;
        logic [NSRC-1:0]  ack_b;
    } ctl_t;

endpackage

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
// Glitch-free gate: the enable is resynchronised on rising edges and
// applied on the falling edge, so the output only ever carries whole pulses.
module clksw_gate #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic clk_o,
    output logic on_o
);

    logic [STAGES-1:0] sync_d, sync_q;
    logic              on_d, on_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], en_i};
        on_d   = sync_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) on_q <= 1'b0;
        else         on_q <= on_d;
    end

    assign clk_o = clk_i & on_q;
    assign on_o  = on_q;

endmodule

// File: rtl/clksw_ctl.sv
`timescale 1ns/1ps
// Control logic in the always-running low-frequency domain: source choice,
// handover bookkeeping, status flags and power mode.
module clksw_ctl
    import clksw_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      src_sel,
    input  logic            int_as_pri,
    input  logic            pri_rdy,
    input  logic            int_stable,
    input  logic            sec_rdy,
    input  logic            sec_keep,
    input  logic [NSRC-1:0] lane_on,
    input  logic            sleep_req,
    input  logic            idle_en,
    input  logic            wake,
    output logic [NSRC-1:0] want_oh,
    output logic            busy_o,
    output logic            flag_pri,
    output logic            flag_int,
    output logic            flag_sec,
    output logic            core_en,
    output logic            per_en
);

    localparam ctl_t RST_VAL = '{
        want:  SRC_PRI,
        cur:   SRC_PRI,
        busy:  1'b1,
        pmode: PM_RUN,
        ack_a: '0,
        ack_b: '0
    };

    ctl_t q, d;
    src_e tgt;
    logic tgt_ok;

    always_comb begin
        unique case (src_sel)
            2'b00:   tgt = int_as_pri ? SRC_INT : SRC_PRI;
            2'b01:   tgt = SRC_SEC;
            2'b10:   tgt = SRC_INT;
            default: tgt = SRC_LF;
        endcase

        unique case (tgt)
            SRC_PRI: tgt_ok = pri_rdy;
            SRC_INT: tgt_ok = int_stable;
            SRC_SEC: tgt_ok = sec_keep | sec_rdy;
            default: tgt_ok = 1'b1;
        endcase

        d       = q;
        d.ack_a = lane_on;
        d.ack_b = q.ack_a;

        if (q.busy) begin
            if (q.ack_b == want_oh) begin
                d.busy = 1'b0;
                d.cur  = q.want;
            end
        end else if ((tgt != q.cur) && tgt_ok) begin
            d.want = tgt;
            d.busy = 1'b1;
        end

        if (wake) begin
            d.pmode = PM_RUN;
        end else if (sleep_req) begin
            d.pmode = idle_en ? PM_IDLE : PM_SLEEP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d;
    end

    always_comb begin
        want_oh = NSRC'(1) << q.want;
        busy_o  = q.busy;
        core_en = (q.pmode == PM_RUN);
        per_en  = (q.pmode != PM_SLEEP);
        unique case (q.cur)
            SRC_PRI: {flag_pri, flag_int, flag_sec} = 3'b100;
            SRC_INT: {flag_pri, flag_int, flag_sec} =
                         {int_as_pri & int_stable, int_stable, 1'b0};
            SRC_SEC: {flag_pri, flag_int, flag_sec} = 3'b001;
            default: {flag_pri, flag_int, flag_sec} = 3'b000;
        endcase
    end

endmodule

// File: rtl/clk_source_switch.sv
`timescale 1ns/1ps
module clk_source_switch
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       rst_ni,
    input  logic       pri_clk,
    input  logic       int_clk,
    input  logic       lf_clk,
    input  logic       sec_clk,
    input  logic       pri_rdy,
    input  logic       int_stable,
    input  logic       sec_rdy,
    input  logic       sec_keep,
    input  logic       int_as_pri,
    input  logic [1:0] src_sel,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic       wake,
    output logic       sys_clk,
    output logic       cpu_clk,
    output logic       per_clk,
    output logic       flag_pri,
    output logic       flag_int,
    output logic       flag_sec,
    output logic       switch_busy
);

    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] lane_clk;
    logic [NSRC-1:0] lane_on;
    logic [NSRC-1:0] lane_en;
    logic [NSRC-1:0] want_oh;
    logic            core_en;
    logic            per_en;
    logic            cpu_on;
    logic            per_on;

    // bit order follows src_e
    assign src_clk = {lf_clk, sec_clk, int_clk, pri_clk};

    clksw_ctl u_ctl (
        .clk_i      (lf_clk),
        .rst_ni     (rst_ni),
        .src_sel    (src_sel),
        .int_as_pri (int_as_pri),
        .pri_rdy    (pri_rdy),
        .int_stable (int_stable),
        .sec_rdy    (sec_rdy),
        .sec_keep   (sec_keep),
        .lane_on    (lane_on),
        .sleep_req  (sleep_req),
        .idle_en    (idle_en),
        .wake       (wake),
        .want_oh    (want_oh),
        .busy_o     (switch_busy),
        .flag_pri   (flag_pri),
        .flag_int   (flag_int),
        .flag_sec   (flag_sec),
        .core_en    (core_en),
        .per_en     (per_en)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
        // a lane may open only once every other lane is closed
        assign lane_en[i] = want_oh[i] & ~(|(lane_on & ~SELF));

        clksw_gate #(.STAGES(SYNC_STAGES)) u_gate (
            .clk_i  (src_clk[i]),
            .rst_ni (rst_ni),
            .en_i   (lane_en[i]),
            .clk_o  (lane_clk[i]),
            .on_o   (lane_on[i])
        );
    end

    assign sys_clk = |lane_clk;

    clksw_gate #(.STAGES(SYNC_STAGES)) u_cpu_gate (
        .clk_i  (sys_clk),
        .rst_ni (rst_ni),
        .en_i   (core_en),
        .clk_o  (cpu_clk),
        .on_o   (cpu_on)
    );

    clksw_gate #(.STAGES(SYNC_STAGES)) u_per_gate (
        .clk_i  (sys_clk),
        .rst_ni (rst_ni),
        .en_i   (per_en),
        .clk_o  (per_clk),
        .on_o   (per_on)
    );

endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk
    import clksw_pkg::*;
(
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] lane_on,
    input logic [NSRC-1:0] want_oh,
    input logic            busy,
    input logic            flag_pri,
    input logic            flag_int,
    input logic            flag_sec,
    input logic            sec_keep,
    input logic            sec_rdy,
    input logic            sleep_req,
    input logic            wake,
    input logic            idle_en,
    input logic            core_en,
    input logic            per_en
);

    // R4
    lane_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lane_on));

    // R8
    want_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && $past(busy)) |-> $stable(want_oh));

    // R5
    handover_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy) |-> (lane_on == want_oh));

    // R3
    flag_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(flag_sec && (flag_pri || flag_int)));

    // R7
    sec_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !sec_keep && !sec_rdy) |=> !$rose(want_oh[SRC_SEC]));

    // R9
    sleep_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_req && !wake) |=> (!core_en && (per_en == $past(idle_en))));

    // R10
    wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake |=> (core_en && per_en));

endmodule

bind clk_source_switch clksw_chk u_chk (
    .clk_i     (lf_clk),
    .rst_ni    (rst_ni),
    .lane_on   (lane_on),
    .want_oh   (want_oh),
    .busy      (switch_busy),
    .flag_pri  (flag_pri),
    .flag_int  (flag_int),
    .flag_sec  (flag_sec),
    .sec_keep  (sec_keep),
    .sec_rdy   (sec_rdy),
    .sleep_req (sleep_req),
    .wake      (wake),
    .idle_en   (idle_en),
    .core_en   (core_en),
    .per_en    (per_en)
);

// File: tb/sim_clk_source_switch.sv
`timescale 1ns/1ps
module sim_clk_source_switch;

    logic rst_ni = 1'b0;
    logic pri_clk = 1'b0, int_clk = 1'b0, lf_clk = 1'b0, sec_clk = 1'b0;
    logic pri_rdy = 1'b1, int_stable = 1'b1, sec_rdy = 1'b0, sec_keep = 1'b1;
    logic int_as_pri = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic sleep_req = 1'b0, idle_en = 1'b0, wake = 1'b0;
    logic sys_clk, cpu_clk, per_clk, flag_pri, flag_int, flag_sec, switch_busy;

    always #5 lf_clk  = ~lf_clk;   // 100 MHz control clock, period 10
    always #3 pri_clk = ~pri_clk;  // period 6
    always #4 int_clk = ~int_clk;  // period 8
    always #7 sec_clk = ~sec_clk;  // period 14

    clk_source_switch u0 (
        .rst_ni(rst_ni), .pri_clk(pri_clk), .int_clk(int_clk), .lf_clk(lf_clk),
        .sec_clk(sec_clk), .pri_rdy(pri_rdy), .int_stable(int_stable),
        .sec_rdy(sec_rdy), .sec_keep(sec_keep), .int_as_pri(int_as_pri),
        .src_sel(src_sel), .sleep_req(sleep_req), .idle_en(idle_en), .wake(wake),
        .sys_clk(sys_clk), .cpu_clk(cpu_clk), .per_clk(per_clk),
        .flag_pri(flag_pri), .flag_int(flag_int), .flag_sec(flag_sec),
        .switch_busy(switch_busy)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // ---------------- monitors ----------------
    realtime t_rise = 0.0, t_fall = 0.0, last_period = 0.0, max_low = 0.0;
    int win_id = 0, seen_id = 0, glitch_cnt = 0;
    int cpu_edges = 0, per_edges = 0, sec_hits = 0;

    always @(posedge sys_clk) begin
        if (win_id != seen_id) begin max_low = 0.0; seen_id = win_id; end
        if (rst_ni && t_fall > 0.0) begin
            if ($realtime - t_fall > max_low) max_low = $realtime - t_fall;
            if ($realtime - t_fall < 2.9) glitch_cnt++;
        end
        if (t_rise > 0.0) last_period = $realtime - t_rise;
        t_rise = $realtime;
    end

    always @(negedge sys_clk) begin
        if (rst_ni && t_rise > 0.0) begin
            int h;
            h = int'(($realtime - t_rise) * 1000.0);
            if (h != 3000 && h != 4000 && h != 5000 && h != 7000) glitch_cnt++;
        end
        t_fall = $realtime;
    end

    always @(posedge cpu_clk) cpu_edges++;
    always @(posedge per_clk) per_edges++;
    always @(posedge lf_clk) if (flag_sec) sec_hits++;

    // ---------------- helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge lf_clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_per(input logic [1:0] code);
        case (code)
            2'b00: return 6;
            2'b01: return 14;
            2'b10: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [2:0] exp_flags(input logic [1:0] code);
        case (code)
            2'b00: return 3'b100;
            2'b01: return 3'b001;
            2'b10: return 3'b010;
            default: return 3'b000;
        endcase
    endfunction

    function automatic int flags();
        return int'({flag_pri, flag_int, flag_sec});
    endfunction

    function automatic int period_ps();
        return int'(last_period * 1000.0);
    endfunction

    task automatic do_sel(input logic [1:0] code, input bit gap_chk);
        int low_ps, tn;
        win_id++;
        src_sel = code;
        step(40);
        tn = exp_per(code) * 1000;
        chk(flags() == int'(exp_flags(code)), "R3", "flags after switch", flags(), int'(exp_flags(code)));
        chk(switch_busy == 1'b0, "R5", "busy after switch", int'(switch_busy), 0);
        chk(period_ps() == tn, "R2", "sys_clk period ps", period_ps(), tn);
        if (gap_chk) begin
            low_ps = (seen_id == win_id) ? int'(max_low * 1000.0) : 0;
            chk(low_ps >= 2 * tn && low_ps <= 3 * tn, "R5", "handover low phase ps", low_ps, 2 * tn);
        end
    endtask

    task automatic gated_counts(output int c, output int p);
        int c0, p0;
        c0 = cpu_edges; p0 = per_edges;
        step(20);
        c = cpu_edges - c0; p = per_edges - p0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0; step(10);
    endtask

    task automatic pulse_wake();
        wake = 1'b1; step(1); wake = 1'b0; step(10);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c, p, cur, h0;
        step(5);
        rst_ni = 1'b1;
        step(1);
        // R1: reset state
        chk(flags() == 3'b100, "R1", "flags right after reset", flags(), 3'b100);
        step(40);
        chk(period_ps() == 6000, "R1", "period after reset ps", period_ps(), 6000);
        gated_counts(c, p);
        chk(c > 0, "R1", "cpu edges after reset", c, 1);
        chk(p > 0, "R1", "per edges after reset", p, 1);

        // R2 R3 R5: every ordered pair of codes
        cur = 0;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    if (a != cur) do_sel(2'(a), 1'b1);
                    do_sel(2'(b), 1'b1);
                    cur = b;
                end
            end
        end

        // R7: secondary waits for ready when keep-alive is low
        do_sel(2'b00, 1'b1);
        sec_keep = 1'b0; sec_rdy = 1'b0;
        src_sel = 2'b01; step(40);
        chk(flags() == 3'b100, "R7", "flags while sec not ready", flags(), 3'b100);
        chk(switch_busy == 1'b0, "R7", "busy while sec not ready", int'(switch_busy), 0);
        sec_rdy = 1'b1; step(40);
        chk(flags() == 3'b001, "R7", "flags after sec ready", flags(), 3'b001);

        // R6: return to primary waits for its ready
        pri_rdy = 1'b0; src_sel = 2'b00; step(40);
        chk(flags() == 3'b001, "R6", "flags while pri not ready", flags(), 3'b001);
        chk(period_ps() == 14000, "R6", "period while pri not ready", period_ps(), 14000);
        pri_rdy = 1'b1; step(40);
        chk(flags() == 3'b100, "R6", "flags after pri ready", flags(), 3'b100);
        int_stable = 1'b0; src_sel = 2'b10; step(40);
        chk(flags() == 3'b100, "R6", "flags while int unstable", flags(), 3'b100);
        int_stable = 1'b1; step(40);
        chk(flags() == 3'b010, "R6", "flags after int stable", flags(), 3'b010);

        // R8: change during a running switch is held off
        do_sel(2'b00, 1'b1);
        sec_keep = 1'b1;
        h0 = sec_hits;
        src_sel = 2'b01; step(2);
        chk(switch_busy == 1'b1, "R5", "busy during switch", int'(switch_busy), 1);
        src_sel = 2'b10; step(60);
        chk(sec_hits - h0 > 0, "R8", "secondary reached first", sec_hits - h0, 1);
        chk(flags() == 3'b010, "R8", "final flags", flags(), 3'b010);
        chk(period_ps() == 8000, "R8", "final period ps", period_ps(), 8000);

        // R9 R10: power modes on the secondary source
        do_sel(2'b01, 1'b1);
        idle_en = 1'b1; pulse_sleep();
        gated_counts(c, p);
        chk(c == 0, "R9", "cpu edges in idle", c, 0);
        chk(p > 0, "R9", "per edges in idle", p, 1);
        idle_en = 1'b0; step(10);
        gated_counts(c, p);
        chk(c == 0, "R9", "cpu edges idle after idle_en change", c, 0);
        chk(p > 0, "R9", "per edges idle after idle_en change", p, 1);
        pulse_wake();
        gated_counts(c, p);
        chk(c > 0 && p > 0, "R10", "both clocks after wake", c, 1);
        chk(flags() == 3'b001, "R10", "flags after wake", flags(), 3'b001);
        chk(period_ps() == 14000, "R10", "period after wake", period_ps(), 14000);
        pulse_sleep();
        gated_counts(c, p);
        chk(c == 0 && p == 0, "R9", "edges in full sleep", c + p, 0);
        pulse_wake();
        gated_counts(c, p);
        chk(c > 0 && p > 0, "R10", "both clocks after second wake", c, 1);

        // R3: internal oscillator as primary
        rst_ni = 1'b0; int_as_pri = 1'b1; src_sel = 2'b00; step(3);
        rst_ni = 1'b1; step(60);
        chk(flags() == 3'b110, "R3", "flags with internal as primary", flags(), 3'b110);
        chk(period_ps() == 8000, "R3", "period with internal as primary", period_ps(), 8000);

        // R4: no runt phases anywhere
        chk(glitch_cnt == 0, "R4", "runt phases on sys_clk", glitch_cnt, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule